// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Read

The block is a free-running up-counter, twice as wide as the data bus, for a small byte-wide peripheral bus. Its clock enable comes from a selectable source. Seven codes pick a power-of-two division of the bus clock, from 1 to 64, taken from a shared divider. The eighth code makes the counter follow rising edges of an external clock pin. That pin is first brought into the bus clock domain, so the whole block runs on a single clock.

Software reads the count one byte at a time. A read of the upper byte copies the lower byte into a holding register, so the two bytes read back belong to the same count value. The copy stays frozen until the lower byte is read. A write-one clear bit in the control register zeroes the counter and restarts the divider, so the next counting interval begins at a known phase.

Top module: `prescaled_timer`

## Requirements
- R1: With select code k from 0 to 6, the counter advances once every 2^k bus cycles. N cycles after a clear with code k, the count is N >> k.
- R2: With select code 7, the counter advances once for each rising edge of `ext_clk_i`, no more than four cycles after the edge. It does not advance without an edge, whatever the divider is doing.
- R3: Address 0 is the control register. Bits [2:0] hold the read/write select code. Bit 4 is a write-one clear that always reads 0. All other bits read 0.
- R4: A read of address 1 returns count bits [15:8]. A read of address 2 returns count bits [7:0]. A read of address 3 returns 0. Read data is valid in the same cycle as `rd_i`.
- R5: A read of address 1 with no copy pending stores the current low byte. The next read of address 2 returns that stored byte.
- R6: While a copy is pending, further reads of address 1 leave the stored byte unchanged. A read of address 2 releases the copy, and after that address 2 returns the live low byte again.
- R7: Writing control bit 4 as 1 zeroes the counter and the divider in the cycle of the write. With code k, the first increment then comes 2^k cycles later.
- R8: The asynchronous reset `rst_ni` clears the count, the select code and any pending copy.
- R9: The counter wraps from 0xFFFF to 0x0000. From one cycle to the next, the count either holds, goes up by one, or drops to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle, zero when not reading |
| ext_clk_i | input | 1 | External count clock, asynchronous, slower than half the bus clock |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 16-bit counter and a 3-bit select code. At these sizes the slowest division of 64 and a full wrap of the counter through 0xFFFF both finish in under 70,000 cycles, so every select code and the wrap can be run cycle-exactly. The expected counts come from the shift rule in R1, and the soft clear sets a known starting point. With the 8-bit bus, the coherent read can be tested across the carry from the low byte into the high byte.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int ADDR_W  = 2;
  localparam int CLR_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_SPARE  = 2'd3
  } pt_reg_e;
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);
  localparam int NSRC  = 2**SEL_W;
  localparam int NDIV  = NSRC - 1;   // internal divide codes
  localparam int DIV_W = NDIV - 1;

  logic [DIV_W-1:0] div_q;
  logic [NSRC-1:0]  tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // tap k fires when the low k divider bits are all ones
  for (genvar k = 0; k < NSRC; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tap[k] = 1'b1;
    end else if (k < NDIV) begin : g_div
      assign tap[k] = &div_q[k-1:0];
    end else begin : g_ext
      assign tap[k] = ext_tick_i;
    end
  end

  assign tick_o = tap[sel_i];
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pt_byte_view.sv
module pt_byte_view #(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*DATA_W-1:0] cnt_i,
  input  logic                rd_hi_i,
  input  logic                rd_lo_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic                pend_o,
  output logic [DATA_W-1:0]   held_o
);
  logic              pend_q;
  logic [DATA_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      held_q <= '0;
    end else if (rd_lo_i) begin
      pend_q <= 1'b0;
    end else if (rd_hi_i && !pend_q) begin
      pend_q <= 1'b1;
      held_q <= cnt_i[DATA_W-1:0];
    end
  end

  assign hi_o   = cnt_i[2*DATA_W-1 -: DATA_W];
  assign lo_o   = pend_q ? held_q : cnt_i[DATA_W-1:0];
  assign pend_o = pend_q;
  assign held_o = held_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [pt_pkg::ADDR_W-1:0] addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  input  logic                   ext_clk_i
);
  import pt_pkg::*;

  localparam int CNT_W = 2 * DATA_W;

  logic [SEL_W-1:0]  sel_q;
  logic              ctrl_wr, soft_clr, ext_tick, tick;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hi_b, lo_b, held;
  logic              pend;
  logic              unused_wdata;

  assign ctrl_wr  = wr_i && (addr_i == REG_CTRL);
  assign soft_clr = ctrl_wr && wdata_i[CLR_BIT];
  assign unused_wdata = ^{wdata_i[DATA_W-1:CLR_BIT+1], wdata_i[CLR_BIT-1:SEL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (ctrl_wr) sel_q <= wdata_i[SEL_W-1:0];
  end

  pt_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (ext_tick)
  );

  pt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_clr),
    .sel_i     (sel_q),
    .ext_tick_i(ext_tick),
    .tick_o    (tick)
  );

  pt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_clr),
    .inc_i (tick),
    .cnt_o (cnt)
  );

  pt_byte_view #(.DATA_W(DATA_W)) u_view (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .rd_hi_i(rd_i && (addr_i == REG_CNT_HI)),
    .rd_lo_i(rd_i && (addr_i == REG_CNT_LO)),
    .hi_o   (hi_b),
    .lo_o   (lo_b),
    .pend_o (pend),
    .held_o (held)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        REG_CTRL:   rdata_o = {{(DATA_W-SEL_W){1'b0}}, sel_q};
        REG_CNT_HI: rdata_o = hi_b;
        REG_CNT_LO: rdata_o = lo_b;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          addr_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [SEL_W-1:0]    sel_q,
  input logic [2*DATA_W-1:0] cnt,
  input logic                pend,
  input logic [DATA_W-1:0]   held
);
  import pt_pkg::*;

  logic clr_w, rd_hi, rd_lo;
  assign clr_w = wr_i && (addr_i == REG_CTRL) && wdata_i[CLR_BIT];
  assign rd_hi = rd_i && (addr_i == REG_CNT_HI);
  assign rd_lo = rd_i && (addr_i == REG_CNT_LO);

  // R1
  div1_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0 && !clr_w) |=> cnt == $past(cnt) + 1'b1);

  // R3
  sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_CTRL) |=> sel_q == $past(wdata_i[SEL_W-1:0]));

  // R4
  hi_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |-> rdata_o == cnt[2*DATA_W-1 -: DATA_W]);

  // R5
  hi_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi && !pend) |=> pend && held == $past(cnt[DATA_W-1:0]));

  // R6
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !rd_lo) |=> pend && $stable(held));

  // R6
  lo_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> !pend);

  // R7
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> cnt == '0);

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

bind prescaled_timer prescaled_timer_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .sel_q  (sel_q),
  .cnt    (cnt),
  .pend   (pend),
  .held   (held)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  import pt_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0, ext = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] wait_c;
    logic [15:0] exp;
  } vec_t;

  // R1: count after N cycles with code k is N >> k
  localparam vec_t VECS [8] = '{
    '{3'd0, 16'd300,   16'd300},
    '{3'd1, 16'd1000,  16'd500},
    '{3'd2, 16'd1030,  16'd257},
    '{3'd3, 16'd2050,  16'd256},
    '{3'd4, 16'd100,   16'd6},
    '{3'd5, 16'd4100,  16'd128},
    '{3'd6, 16'd16383, 16'd255},
    '{3'd6, 16'd16384, 16'd256}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] q);
    addr = a; rd = 1'b1;
    #1 q = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] h, l, h2, l2, c;
    @(negedge clk);
    // R8: state under reset
    rd_reg(REG_CTRL, c);   check("R8 ctrl", {8'h00, c}, 16'h0000);
    rd_reg(REG_CNT_HI, h); check("R8 hi",   {8'h00, h}, 16'h0000);
    rd_reg(REG_CNT_LO, l); check("R8 lo",   {8'h00, l}, 16'h0000);
    rst_n = 1'b1;
    idle(3);

    // R1: every divide code from a clean clear
    for (int i = 0; i < 8; i++) begin
      wr_reg(REG_CTRL, {3'b000, 1'b1, 1'b0, VECS[i].sel});
      idle(int'(VECS[i].wait_c));
      rd_reg(REG_CNT_HI, h);
      rd_reg(REG_CNT_LO, l);
      check($sformatf("R1 code %0d", VECS[i].sel), {h, l}, VECS[i].exp);
    end

    // R3: select readback, clear bit and spare bits read 0
    wr_reg(REG_CTRL, 8'hE5);
    rd_reg(REG_CTRL, c); check("R3 ctrl readback", {8'h00, c}, 16'h0005);
    // R4: spare address
    rd_reg(REG_SPARE, c); check("R4 spare", {8'h00, c}, 16'h0000);

    // R7: clear restarts divider phase (code 4)
    wr_reg(REG_CTRL, 8'h04);
    idle(7);
    wr_reg(REG_CTRL, 8'h14);
    idle(15);
    rd_reg(REG_CNT_LO, l); check("R7 before first tick", {8'h00, l}, 16'h0000);
    rd_reg(REG_CNT_LO, l); check("R7 first tick", {8'h00, l}, 16'h0001);

    // R5 R6: coherent read across a low-byte carry
    wr_reg(REG_CTRL, 8'h10);
    idle(253);
    rd_reg(REG_CNT_HI, h);   check("R5 hi at 0x00FD", {8'h00, h}, 16'h0000);
    idle(4);
    rd_reg(REG_CNT_HI, h2);  check("R6 second hi live", {8'h00, h2}, 16'h0001);
    rd_reg(REG_CNT_LO, l);   check("R6 held low kept", {8'h00, l}, 16'h00FD);
    rd_reg(REG_CNT_LO, l2);  check("R6 live low after release", {8'h00, l2}, 16'h0004);

    // R9: wrap
    wr_reg(REG_CTRL, 8'h10);
    idle(65535);
    rd_reg(REG_CNT_HI, h); rd_reg(REG_CNT_LO, l);
    check("R9 top value", {h, l}, 16'hFFFF);
    rd_reg(REG_CNT_HI, h); rd_reg(REG_CNT_LO, l);
    check("R9 wrapped", {h, l}, 16'h0001);

    // R2: external clock
    wr_reg(REG_CTRL, 8'h17);
    idle(100);
    rd_reg(REG_CNT_HI, h); rd_reg(REG_CNT_LO, l);
    check("R2 no edges no count", {h, l}, 16'h0000);
    for (int p = 0; p < 5; p++) begin
      ext = 1'b1; idle(4);
      ext = 1'b0; idle(4);
    end
    idle(6);
    rd_reg(REG_CNT_HI, h); rd_reg(REG_CNT_LO, l);
    check("R2 five edges", {h, l}, 16'h0005);
    idle(100);
    rd_reg(REG_CNT_HI, h); rd_reg(REG_CNT_LO, l);
    check("R2 hold without edges", {h, l}, 16'h0005);
    rd_reg(REG_CTRL, c); check("R3 ext code readback", {8'h00, c}, 16'h0007);

    // R8: reset mid-run clears select and count
    wr_reg(REG_CTRL, 8'h03);
    idle(40);
    rd_reg(REG_CNT_HI, h);
    rst_n = 1'b0;
    #1;
    rd_reg(REG_CTRL, c);   check("R8 ctrl after reset", {8'h00, c}, 16'h0000);
    rd_reg(REG_CNT_LO, l); check("R8 count after reset", {8'h00, l}, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule